// File: doc/BRIEF.md
# PLL Reference and Output Divider Control

This block holds the synchronous divide and selection logic that sits around an analog phase-locked loop. It chooses the loop reference from either a trimmed internal oscillator, which is used undivided, or an external crystal oscillator, which first passes through a programmable pre-divider. On the output side it divides the VCO clock by a programmable ratio while the loop reports lock. While the loop is unlocked it falls back to a fixed divide-by-4.

A bus clock is derived at half the rate of either the PLL output or the reference. A glitch-free clock switch chooses between the two. The 6-bit multiply setting is passed straight through to the analog core. The VCO, phase detector and loop filter are outside this block.

Every divider loads a new ratio only at its terminal count. A ratio of 1 routes the input clock straight through. Other ratios give a period of exactly ratio input cycles, with an uneven duty cycle for odd ratios.

Top module: `pll_div_ctrl`

## Requirements
- R1: With the oscillator select input low, the reference output toggles at the internal oscillator clock rate, undivided.
- R2: With the oscillator select input high, the reference output period equals (ref_div_i + 1) external oscillator periods. A value of 0 passes the oscillator clock straight through.
- R3: With lock_i high, the PLL output period equals (post_div_i + 1) VCO periods, for every value 0 to 31.
- R4: With lock_i low, the PLL output period equals exactly 4 VCO periods, whatever post_div_i holds.
- R5: With pll_sel_i high, the bus clock period equals twice the PLL output period.
- R6: With pll_sel_i low, the bus clock period equals twice the reference output period.
- R7: mul_o always equals mul_i.
- R8: A divider loads a changed ratio or lock state only at its terminal count. Its counter never passes the latched terminal value. After a change, the next complete period already uses the new ratio.
- R9: While rst_ni is low, the reference, PLL and bus clocks are all held low.
- R10: The two clock-switch stages never enable both of their sources at the same time. The bus clock settles to the newly selected source after a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_irc_i | input | 1 | Trimmed internal oscillator clock |
| clk_osc_i | input | 1 | External crystal oscillator clock |
| clk_vco_i | input | 1 | VCO clock from the analog core |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Lock flag from the analog core (asynchronous) |
| osc_en_i | input | 1 | 1 selects the divided external oscillator as the reference |
| ref_div_i | input | 4 | Reference pre-divide ratio minus one |
| post_div_i | input | 5 | Post-divide ratio minus one, used while locked |
| mul_i | input | 6 | VCO multiply setting |
| pll_sel_i | input | 1 | 1 takes the bus clock from the PLL output |
| mul_o | output | 6 | Multiply setting passed to the analog core |
| clk_ref_o | output | 1 | Reference clock to the loop |
| clk_pll_o | output | 1 | PLL output clock |
| clk_bus_o | output | 1 | Bus clock |

## Verification
A lock change and a post-divide change can reach the VCO-side divider in the same period. Both must then be absorbed at a single terminal count. The bench provokes this by randomly toggling lock_i, post_div_i and pll_sel_i together. It judges the result by the output period it measures after settling: the period must be 4 VCO cycles when unlocked and the programmed ratio when locked. The bus period seen through the switch must also be twice the selected source period.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;
  localparam int REF_DIV_W  = 4;
  localparam int POST_DIV_W = 5;
  localparam int MUL_W      = 6;
  localparam int UNLOCK_DIV = 4;
endpackage

// File: rtl/pdc_clk_div.sv
`timescale 1ns/1ps
module pdc_clk_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_m1_i,
  output logic         clk_o
);
  localparam int HW = W + 1;

  logic [W-1:0]  cnt_q, n_q, cnt_d, n_d;
  logic [HW-1:0] half;
  logic          q_q, byp_q, term;

  assign term  = (cnt_q == n_q);
  assign n_d   = term ? ratio_m1_i : n_q;
  assign cnt_d = term ? '0 : cnt_q + 1'b1;
  assign half  = ({1'b0, n_d} + HW'(1)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      n_q   <= '0;
      q_q   <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
      q_q   <= ({1'b0, cnt_d} < half);
      if (term) byp_q <= (ratio_m1_i == '0);
    end
  end

  // ratio 1: pass-through; selection changes only at terminal count
  assign clk_o = byp_q ? clk_i : q_q;

  a_r8_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != n_q) |=> $stable(n_q));

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_q);
endmodule

// File: rtl/pdc_clk_gmux.sv
`timescale 1ns/1ps
module pdc_clk_gmux (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic clk_o
);
  logic s0_a, s0_b, s1_a, s1_b;

  always_ff @(posedge clk0_i or negedge rst_ni)
    if (!rst_ni) s0_a <= 1'b0;
    else         s0_a <= !sel_i && !s1_b;

  always_ff @(negedge clk0_i or negedge rst_ni)
    if (!rst_ni) s0_b <= 1'b0;
    else         s0_b <= s0_a;

  always_ff @(posedge clk1_i or negedge rst_ni)
    if (!rst_ni) s1_a <= 1'b0;
    else         s1_a <= sel_i && !s0_b;

  always_ff @(negedge clk1_i or negedge rst_ni)
    if (!rst_ni) s1_b <= 1'b0;
    else         s1_b <= s1_a;

  assign clk_o = (clk0_i & s0_b) | (clk1_i & s1_b);

  a_r10_one_src_0: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    !(s0_b && s1_b));

  a_r10_one_src_1: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    !(s0_b && s1_b));
endmodule

// File: rtl/pll_div_ctrl.sv
`timescale 1ns/1ps
module pll_div_ctrl
  import pll_div_pkg::*;
#(
  parameter int REF_W  = REF_DIV_W,
  parameter int POST_W = POST_DIV_W,
  parameter int MUL_WD = MUL_W
) (
  input  logic              clk_irc_i,
  input  logic              clk_osc_i,
  input  logic              clk_vco_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              osc_en_i,
  input  logic [REF_W-1:0]  ref_div_i,
  input  logic [POST_W-1:0] post_div_i,
  input  logic [MUL_WD-1:0] mul_i,
  input  logic              pll_sel_i,
  output logic [MUL_WD-1:0] mul_o,
  output logic              clk_ref_o,
  output logic              clk_pll_o,
  output logic              clk_bus_o
);
  localparam logic [POST_W-1:0] UNLOCK_M1 = POST_W'(UNLOCK_DIV - 1);

  logic              lock_m, lock_s;
  logic [POST_W-1:0] post_m1;
  logic              osc_div, bus_src;

  assign mul_o = mul_i;

  always_ff @(posedge clk_vco_i or negedge rst_ni)
    if (!rst_ni) {lock_s, lock_m} <= 2'b00;
    else         {lock_s, lock_m} <= {lock_m, lock_i};

  assign post_m1 = lock_s ? post_div_i : UNLOCK_M1;

  pdc_clk_div #(.W(REF_W)) u_ref_div (
    .clk_i(clk_osc_i), .rst_ni(rst_ni), .ratio_m1_i(ref_div_i), .clk_o(osc_div));

  pdc_clk_gmux u_ref_mux (
    .clk0_i(clk_irc_i), .clk1_i(osc_div), .rst_ni(rst_ni),
    .sel_i(osc_en_i), .clk_o(clk_ref_o));

  pdc_clk_div #(.W(POST_W)) u_post_div (
    .clk_i(clk_vco_i), .rst_ni(rst_ni), .ratio_m1_i(post_m1), .clk_o(clk_pll_o));

  pdc_clk_gmux u_bus_mux (
    .clk0_i(clk_ref_o), .clk1_i(clk_pll_o), .rst_ni(rst_ni),
    .sel_i(pll_sel_i), .clk_o(bus_src));

  pdc_clk_div #(.W(1)) u_bus_div (
    .clk_i(bus_src), .rst_ni(rst_ni), .ratio_m1_i(1'b1), .clk_o(clk_bus_o));

  a_r4_unlock_ratio: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    (!lock_s && u_post_div.cnt_q == u_post_div.n_q) |=> (u_post_div.n_q == UNLOCK_M1));

  a_r3_lock_ratio: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    (lock_s && u_post_div.cnt_q == u_post_div.n_q) |=> (u_post_div.n_q == $past(post_div_i)));
endmodule

// File: tb/sim_pll_div_ctrl.sv
`timescale 1ns/1ps
module sim_pll_div_ctrl;
  localparam int VCO_P = 4;   // 250 MHz
  localparam int OSC_P = 6;
  localparam int IRC_P = 14;

  logic clk_irc = 0, clk_osc = 0, clk_vco = 0, rst_n = 0;
  logic lock = 0, osc_en = 0, pll_sel = 0;
  logic [3:0] ref_div = '0;
  logic [4:0] post_div = '0;
  logic [5:0] mul = '0, mul_out;
  logic ref_o, pll_o, bus_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(VCO_P/2) clk_vco = ~clk_vco;
  always #(OSC_P/2) clk_osc = ~clk_osc;
  always #(IRC_P/2) clk_irc = ~clk_irc;

  pll_div_ctrl u0 (
    .clk_irc_i(clk_irc), .clk_osc_i(clk_osc), .clk_vco_i(clk_vco), .rst_ni(rst_n),
    .lock_i(lock), .osc_en_i(osc_en), .ref_div_i(ref_div), .post_div_i(post_div),
    .mul_i(mul), .pll_sel_i(pll_sel), .mul_o(mul_out),
    .clk_ref_o(ref_o), .clk_pll_o(pll_o), .clk_bus_o(bus_o));

  function automatic longint exp_ref(bit oe, int d);
    return oe ? OSC_P * (d + 1) : IRC_P;
  endfunction
  function automatic longint exp_pll(bit lk, int d);
    return VCO_P * (lk ? d + 1 : 4);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic per_ref(output longint p);
    longint t0;
    repeat (4) @(posedge ref_o);
    t0 = $time; @(posedge ref_o); p = $time - t0;
  endtask
  task automatic per_pll(output longint p);
    longint t0;
    repeat (4) @(posedge pll_o);
    t0 = $time; @(posedge pll_o); p = $time - t0;
  endtask
  task automatic per_bus(output longint p);
    longint t0;
    repeat (4) @(posedge bus_o);
    t0 = $time; @(posedge bus_o); p = $time - t0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(VCO_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    longint p, t0;
    int s;
    s = $urandom(32'h5eed1234);
    mul = 6'h2a;
    #21;
    chk("R9 ref low in reset", longint'(ref_o), 0);
    chk("R9 pll low in reset", longint'(pll_o), 0);
    chk("R9 bus low in reset", longint'(bus_o), 0);
    chk("R7 mul pass", longint'(mul_out), 42);
    @(negedge clk_vco); rst_n = 1;

    per_ref(p); chk("R1 irc ref", p, exp_ref(0, 0));
    per_bus(p); chk("R6 bus from irc ref", p, 2 * exp_ref(0, 0));

    osc_en = 1;
    for (int d = 0; d < 16; d++) begin
      ref_div = 4'(d);
      per_ref(p); chk("R2 osc ref ratio", p, exp_ref(1, d));
    end

    lock = 1;
    for (int d = 0; d < 32; d++) begin
      @(negedge clk_vco); post_div = 5'(d);
      per_pll(p); chk("R3 locked ratio", p, exp_pll(1, d));
    end
    lock = 0;
    for (int d = 0; d < 32; d++) begin
      @(negedge clk_vco); post_div = 5'(d);
      per_pll(p); chk("R4 unlocked fixed", p, exp_pll(0, d));
    end

    lock = 1; post_div = 5'd2; pll_sel = 1;
    per_bus(p); chk("R5 bus from pll", p, 2 * exp_pll(1, 2));
    pll_sel = 0; ref_div = 4'd2;
    per_bus(p); chk("R10 R6 bus back to ref", p, 2 * exp_ref(1, 2));

    // R8: change mid-period, next full period uses new ratio
    @(negedge clk_vco); post_div = 5'd5;
    per_pll(p);
    repeat (3) @(negedge clk_vco);
    post_div = 5'd1;
    @(posedge pll_o); t0 = $time; @(posedge pll_o); p = $time - t0;
    chk("R8 change at terminal", p, exp_pll(1, 1));

    for (int i = 0; i < 20; i++) begin
      @(negedge clk_vco);
      lock     = 1'($urandom);
      osc_en   = 1'($urandom);
      pll_sel  = 1'($urandom);
      ref_div  = 4'($urandom);
      post_div = 5'($urandom);
      mul      = 6'($urandom);
      #1 chk("R7 mul random", longint'(mul_out), longint'(mul));
      per_ref(p); chk("R1 R2 random ref", p, exp_ref(osc_en, int'(ref_div)));
      per_pll(p); chk("R3 R4 random pll", p, exp_pll(lock, int'(post_div)));
      per_bus(p);
      chk("R5 R6 random bus", p,
          pll_sel ? 2 * exp_pll(lock, int'(post_div)) : 2 * exp_ref(osc_en, int'(ref_div)));
    end

    done = 1;
    finish_run();
  end
endmodule